// File: doc/BRIEF.md
# Multiplexed Front-End Readout Sequencer

This block is the digital controller for a multi-channel charge-measurement front-end chip. It has one held sample per channel and two serial shift registers on the chip side. When a trigger arrives while the block is idle, it starts one readout. First it holds the chip reset for a fixed number of cycles. This clears both on-chip registers, so an upset from an earlier readout cannot build up. In calibration mode it then serially loads a one-hot channel pattern into the calibration-select register. It shifts the same pattern through a second time and compares each bit that comes back, which confirms the load. Only when every bit matches does it fire the calibration pulse.

After a settle interval the block asserts the simultaneous hold of all shaper outputs. It clocks a single logic-1 token through the output shift register, so that channel 0 up to channel NCH-1 reach the analogue buffer in turn. After each token clock it issues an ADC convert strobe that carries the channel index. At each convert strobe it samples the returned shift-out pin. The token is expected there only after the last clock, and any other value marks the packet as upset. Each readout ends with a one-cycle packet-end pulse carrying a wrapping sequence number. The upset and calibration flags are cleared when the next readout starts, so a corrupted readout affects only its own packet.

Top module: `fe_readout_seq`

## Requirements
- R1: While reset is held and after its release with no trigger, busy, fe_rst, fe_hold, fe_clk, fe_shift_in, adc_conv, cal_clk, cal_fire, pkt_end and pkt_upset are 0, and pkt_seq is 0.
- R2: A trigger in idle starts a readout whose first RST_CYC cycles assert fe_rst. A trigger while busy is ignored: it starts no packet and does not change the latched channel or mode.
- R3: In calibration mode (cal_mode=1 at the trigger), the block gives 2*NCH cal_clk pulses. The cal_din bit that goes with the k-th pulse of each half is bit NCH-1-k of the one-hot pattern (1 << cal_chan), so bit NCH-1 goes first. After these pulses the chip's register (shifting in at bit 0) holds the pattern. In normal mode there are no cal_clk pulses and no cal_fire.
- R4: cal_readback is compared with cal_din only on the cal_clk pulses of the second half. If all of them match, cal_fire gives exactly one pulse after the last cal_clk. On any mismatch, cal_err is set and stays set until the next readout starts, and cal_fire stays low.
- R5: fe_hold is high without a break from the first token clock to the last convert strobe. fe_shift_in is high on the first fe_clk only, so exactly one token is shifted per readout.
- R6: A readout gives exactly NCH adc_conv pulses, each in the cycle after an fe_clk pulse, with ch_idx counting 0, 1, ..., NCH-1.
- R7: fe_shift_out is sampled at each adc_conv. It must be 1 at ch_idx=NCH-1 and 0 at every other index. Any deviation raises pkt_upset together with that readout's pkt_end, and the flag is not carried into the next packet.
- R8: pkt_end is a one-cycle pulse that ends each readout. pkt_seq is 0 for the first packet after reset, increases by one after each packet and wraps modulo 2^SEQ_W.
- R9: busy lasts exactly RST_CYC + SETTLE_CYC + 2*NCH + 1 cycles in normal mode, plus 4*NCH + 1 in calibration mode. This stays below MAX_CYC (6250 cycles, 50 us at 125 MHz, by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Readout request, sampled in idle |
| cal_mode | input | 1 | 1 = calibration mode, latched at trigger |
| cal_chan | input | $clog2(NCH) | Channel given the calibration pulse, latched at trigger |
| fe_shift_out | input | 1 | Token returned by the output shift register |
| cal_readback | input | 1 | Serial output of the calibration-select register |
| busy | output | 1 | Readout in progress |
| fe_rst | output | 1 | Chip register reset |
| fe_hold | output | 1 | Sample-and-hold of all shaper outputs |
| fe_clk | output | 1 | Output shift register clock pulse |
| fe_shift_in | output | 1 | Token input of the output shift register |
| adc_conv | output | 1 | ADC convert strobe |
| ch_idx | output | $clog2(NCH) | Channel now presented to the buffer |
| cal_clk | output | 1 | Calibration register clock pulse |
| cal_din | output | 1 | Calibration register serial data |
| cal_fire | output | 1 | Calibration pulse trigger |
| cal_err | output | 1 | Calibration readback mismatch |
| pkt_end | output | 1 | End of packet |
| pkt_seq | output | SEQ_W | Packet sequence number |
| pkt_upset | output | 1 | Packet upset flag, valid with pkt_end |

## Verification
The bench builds the block with NCH=8, RST_CYC=3, SETTLE_CYC=4, SEQ_W=3 and MAX_CYC=100. It drives a behavioural model of both chip shift registers with fault injection. Eight channels keep each readout under a hundred cycles, so every token position, including a token lost at the final clock, can be corrupted in a short run. A 3-bit sequence number wraps after eight packets, so the modulo behaviour comes within reach of a short run.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RST,
    PH_CAL,
    PH_FIRE,
    PH_SETTLE,
    PH_SHIFT,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/fe_phase_ctrl.sv
module fe_phase_ctrl
  import fe_seq_pkg::*;
#(
  parameter int NCH        = 32,
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 8,
  parameter int SW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          cal_mode,
  output phase_t        phase_o,
  output logic [SW-1:0] step_o,
  output logic          start_o
);
  localparam logic [SW-1:0] LAST_RST = SW'(RST_CYC - 1);
  localparam logic [SW-1:0] LAST_CAL = SW'(4 * NCH - 1);
  localparam logic [SW-1:0] LAST_SET = SW'(SETTLE_CYC - 1);
  localparam logic [SW-1:0] LAST_SHF = SW'(2 * NCH - 1);

  phase_t        phase_q, phase_d;
  logic [SW-1:0] step_q, step_d;
  logic          mode_q, mode_d;
  logic [SW-1:0] last;

  always_comb begin
    case (phase_q)
      PH_RST:    last = LAST_RST;
      PH_CAL:    last = LAST_CAL;
      PH_SETTLE: last = LAST_SET;
      PH_SHIFT:  last = LAST_SHF;
      default:   last = '0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    mode_d  = mode_q;
    start_o = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (trig) begin
        phase_d = PH_RST;
        step_d  = '0;
        mode_d  = cal_mode;
        start_o = 1'b1;
      end
    end else if (step_q != last) begin
      step_d = step_q + 1'b1;
    end else begin
      step_d = '0;
      case (phase_q)
        PH_RST:    phase_d = mode_q ? PH_CAL : PH_SETTLE;
        PH_CAL:    phase_d = PH_FIRE;
        PH_FIRE:   phase_d = PH_SETTLE;
        PH_SETTLE: phase_d = PH_SHIFT;
        PH_SHIFT:  phase_d = PH_DONE;
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      mode_q  <= mode_d;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
endmodule

// File: rtl/fe_cal_loader.sv
module fe_cal_loader #(
  parameter int NCH = 32,
  parameter int SW  = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] chan,
  input  logic           active,
  input  logic           clr,
  input  logic [SW-1:0]  step,
  input  logic           readback,
  output logic           cal_clk,
  output logic           cal_din,
  output logic           err
);
  localparam logic [SW-1:0]  HALF = SW'(2 * NCH);
  localparam logic [CHW-1:0] TOP  = CHW'(NCH - 1);

  logic [CHW-1:0] chan_q;
  logic           err_q, err_d;
  logic [NCH-1:0] pat;
  logic           second;
  logic [SW-1:0]  rel;
  logic [CHW-1:0] bsel;

  always_comb begin
    pat    = NCH'(1) << chan_q;
    second = (step >= HALF);
    rel    = second ? (step - HALF) : step;
    bsel   = TOP - CHW'(rel >> 1);
    cal_din = active & pat[bsel];
    cal_clk = active & rel[0];
  end

  always_comb begin
    err_d = err_q;
    if (clr) err_d = 1'b0;
    else if (cal_clk && second && (readback != cal_din)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (start) chan_q <= chan;
      err_q <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/fe_token_check.sv
module fe_token_check #(
  parameter int NCH = 32,
  parameter int SW  = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           clr,
  input  logic [SW-1:0]  step,
  input  logic           shift_out,
  output logic           fe_clk,
  output logic           shift_in,
  output logic           conv,
  output logic [CHW-1:0] ch_idx,
  output logic           err
);
  localparam logic [CHW-1:0] TOP = CHW'(NCH - 1);

  logic err_q, err_d;
  logic expect_tok;

  always_comb begin
    fe_clk     = active & ~step[0];
    shift_in   = active & (step == '0);
    conv       = active & step[0];
    ch_idx     = active ? CHW'(step >> 1) : '0;
    expect_tok = (ch_idx == TOP);
  end

  always_comb begin
    err_d = err_q;
    if (clr) err_d = 1'b0;
    else if (conv && (shift_out != expect_tok)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/fe_readout_seq.sv
module fe_readout_seq
  import fe_seq_pkg::*;
#(
  parameter int NCH        = 32,
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 8,
  parameter int SEQ_W      = 8,
  parameter int MAX_CYC    = 6250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig,
  input  logic                   cal_mode,
  input  logic [$clog2(NCH)-1:0] cal_chan,
  input  logic                   fe_shift_out,
  input  logic                   cal_readback,
  output logic                   busy,
  output logic                   fe_rst,
  output logic                   fe_hold,
  output logic                   fe_clk,
  output logic                   fe_shift_in,
  output logic                   adc_conv,
  output logic [$clog2(NCH)-1:0] ch_idx,
  output logic                   cal_clk,
  output logic                   cal_din,
  output logic                   cal_fire,
  output logic                   cal_err,
  output logic                   pkt_end,
  output logic [SEQ_W-1:0]       pkt_seq,
  output logic                   pkt_upset
);
  localparam int CHW  = $clog2(NCH);
  localparam int M1   = (RST_CYC > 4 * NCH) ? RST_CYC : 4 * NCH;
  localparam int MAXL = (SETTLE_CYC > M1) ? SETTLE_CYC : M1;
  localparam int SW   = $clog2(MAXL + 1);

  phase_t           phase;
  logic [SW-1:0]    step;
  logic             start;
  logic             tok_err;
  logic [SEQ_W-1:0] seq_q, seq_d;

  fe_phase_ctrl #(.NCH(NCH), .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cal_mode(cal_mode),
    .phase_o(phase), .step_o(step), .start_o(start)
  );

  fe_cal_loader #(.NCH(NCH), .SW(SW), .CHW(CHW)) u_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(cal_chan),
    .active(phase == PH_CAL), .clr(phase == PH_RST), .step(step),
    .readback(cal_readback), .cal_clk(cal_clk), .cal_din(cal_din), .err(cal_err)
  );

  fe_token_check #(.NCH(NCH), .SW(SW), .CHW(CHW)) u_tok (
    .clk(clk), .rst_n(rst_n), .active(phase == PH_SHIFT),
    .clr(phase == PH_RST), .step(step), .shift_out(fe_shift_out),
    .fe_clk(fe_clk), .shift_in(fe_shift_in), .conv(adc_conv),
    .ch_idx(ch_idx), .err(tok_err)
  );

  always_comb begin
    busy      = (phase != PH_IDLE);
    fe_rst    = (phase == PH_RST);
    fe_hold   = (phase == PH_SHIFT);
    cal_fire  = (phase == PH_FIRE) & ~cal_err;
    pkt_end   = (phase == PH_DONE);
    pkt_upset = pkt_end & tok_err;
    seq_d     = pkt_end ? seq_q + 1'b1 : seq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else        seq_q <= seq_d;
  end

  assign pkt_seq = seq_q;
endmodule

// File: rtl/fe_readout_seq_chk.sv
module fe_readout_seq_chk #(
  parameter int NCH     = 32,
  parameter int SEQ_W   = 8,
  parameter int MAX_CYC = 6250
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   fe_rst,
  input logic                   fe_hold,
  input logic                   fe_clk,
  input logic                   fe_shift_in,
  input logic                   adc_conv,
  input logic [$clog2(NCH)-1:0] ch_idx,
  input logic                   cal_clk,
  input logic                   cal_fire,
  input logic                   cal_err,
  input logic                   pkt_end,
  input logic [SEQ_W-1:0]       pkt_seq,
  input logic                   pkt_upset
);
  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(MAX_CYC + 1);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fe_rst);
  a_r3_calclk_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_clk |-> busy && !fe_rst && !fe_hold);
  a_r4_fire_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fire |-> !cal_err && $past(cal_clk));
  a_r5_token_on_clk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_shift_in |-> fe_clk && fe_hold);
  a_r5_hold_conv: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> fe_hold);
  a_r6_conv_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> $past(fe_clk));
  a_r6_ch_order: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_conv && ch_idx != '0) |-> $past(adc_conv, 2) && (ch_idx == CHW'($past(ch_idx, 2) + 1'b1)));
  a_r7_upset_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_upset |-> pkt_end);
  a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (pkt_seq == SEQ_W'($past(pkt_seq) + 1'b1)) && !pkt_end);
  a_r9_time_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < CW'(MAX_CYC));
endmodule

bind fe_readout_seq fe_readout_seq_chk #(.NCH(NCH), .SEQ_W(SEQ_W), .MAX_CYC(MAX_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fe_rst(fe_rst), .fe_hold(fe_hold),
  .fe_clk(fe_clk), .fe_shift_in(fe_shift_in), .adc_conv(adc_conv), .ch_idx(ch_idx),
  .cal_clk(cal_clk), .cal_fire(cal_fire), .cal_err(cal_err), .pkt_end(pkt_end),
  .pkt_seq(pkt_seq), .pkt_upset(pkt_upset)
);

// File: tb/test_fe_readout_seq.sv
module test_fe_readout_seq;
  localparam int N   = 8;
  localparam int RC  = 3;
  localparam int SC  = 4;
  localparam int SQW = 3;
  localparam int CHW = $clog2(N);

  typedef struct packed {
    logic           mode;
    logic [CHW-1:0] chan;
    logic [3:0]     flip;
    logic           calbad;
    logic           exp_up;
    logic           exp_err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd3, 4'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd7, 4'd0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 3'd0, 4'd2, 1'b0, 1'b1, 1'b0},
    '{1'b1, 3'd0, 4'd8, 1'b0, 1'b1, 1'b0},
    '{1'b0, 3'd5, 4'd0, 1'b0, 1'b0, 1'b0}
  };

  logic clk, rst_n, trig, cal_mode;
  logic [CHW-1:0] cal_chan, ch_idx;
  logic fe_shift_out, cal_readback;
  logic busy, fe_rst, fe_hold, fe_clk, fe_shift_in, adc_conv;
  logic cal_clk, cal_din, cal_fire, cal_err, pkt_end, pkt_upset;
  logic [SQW-1:0] pkt_seq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fe_readout_seq #(.NCH(N), .RST_CYC(RC), .SETTLE_CYC(SC), .SEQ_W(SQW), .MAX_CYC(100)) i_fe_readout_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cal_mode(cal_mode), .cal_chan(cal_chan),
    .fe_shift_out(fe_shift_out), .cal_readback(cal_readback), .busy(busy),
    .fe_rst(fe_rst), .fe_hold(fe_hold), .fe_clk(fe_clk), .fe_shift_in(fe_shift_in),
    .adc_conv(adc_conv), .ch_idx(ch_idx), .cal_clk(cal_clk), .cal_din(cal_din),
    .cal_fire(cal_fire), .cal_err(cal_err), .pkt_end(pkt_end), .pkt_seq(pkt_seq),
    .pkt_upset(pkt_upset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // chip model with fault injection
  logic [N-1:0] out_reg, cal_reg, nxt;
  int fclk_n;
  int flip_at;
  logic calbad;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || fe_rst) begin
      out_reg <= '0;
      cal_reg <= '0;
      fclk_n  <= 0;
    end else begin
      if (fe_clk) begin
        nxt = {out_reg[N-2:0], fe_shift_in};
        if (fclk_n + 1 == flip_at) nxt[N-1] = ~nxt[N-1];
        out_reg <= nxt;
        fclk_n  <= fclk_n + 1;
      end
      if (cal_clk) cal_reg <= {cal_reg[N-2:0], cal_din};
    end
  end

  assign fe_shift_out = out_reg[N-1];
  assign cal_readback = cal_reg[N-1] ^ calbad;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // per-readout observations
  int o_busy, o_rst, o_calclk, o_fire, o_conv, o_order_bad, o_hold_bad;
  int o_tok, o_end, o_up, o_fire_pat, o_seq, o_calerr;

  task automatic readout(input logic mode, input logic [CHW-1:0] chan, input bit extra_trig);
    int guard;
    int exp_ch;
    o_busy = 0; o_rst = 0; o_calclk = 0; o_fire = 0; o_conv = 0; o_order_bad = 0;
    o_hold_bad = 0; o_tok = 0; o_end = 0; o_up = 0; o_fire_pat = -1; o_seq = -1; o_calerr = 0;
    exp_ch = 0;
    guard = 0;
    @(negedge clk);
    cal_mode = mode; cal_chan = chan; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0; cal_mode = ~mode;
    while (busy && guard < 1000) begin
      guard++;
      o_busy++;
      if (fe_rst) o_rst++;
      if (cal_clk) o_calclk++;
      if (cal_fire) begin o_fire++; o_fire_pat = int'(cal_reg); end
      if (fe_shift_in) o_tok++;
      if (adc_conv) begin
        o_conv++;
        if (int'(ch_idx) != exp_ch) o_order_bad++;
        if (!fe_hold) o_hold_bad++;
        exp_ch++;
      end
      if (pkt_end) begin o_end++; o_up = pkt_upset; o_seq = pkt_seq; o_calerr = cal_err; end
      if (extra_trig && guard == 10) begin trig = 1'b1; cal_chan = chan + 1'b1; cal_mode = 1'b0; end
      if (extra_trig && guard == 11) trig = 1'b0;
      @(negedge clk);
    end
    if (guard >= 1000) check("R9", guard, 0, "readout hung");
    repeat (3) begin
      if (pkt_end || busy) o_end++;
      @(negedge clk);
    end
  endtask

  int seq_exp = 0;

  initial begin
    rst_n = 1'b0; trig = 1'b0; cal_mode = 1'b0; cal_chan = '0;
    flip_at = 0; calbad = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {busy, fe_rst, fe_hold, fe_clk, fe_shift_in, adc_conv, cal_clk, cal_fire, pkt_end, pkt_upset}, 0, "outputs in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {busy, fe_rst, fe_hold, fe_clk, cal_clk, pkt_end}, 0, "idle after reset");
    check("R1", pkt_seq, 0, "seq after reset");

    for (int v = 0; v < NV; v++) begin
      flip_at = VECS[v].flip;
      calbad  = VECS[v].calbad;
      readout(VECS[v].mode, VECS[v].chan, 1'b0);
      check("R9", o_busy, RC + SC + 2 * N + 1 + (VECS[v].mode ? 4 * N + 1 : 0), "busy length");
      check("R2", o_rst, RC, "reset cycles");
      check("R3", o_calclk, VECS[v].mode ? 2 * N : 0, "cal clock count");
      check("R4", o_fire, (VECS[v].mode && !VECS[v].exp_err) ? 1 : 0, "fire count");
      if (VECS[v].mode && !VECS[v].exp_err)
        check("R3", o_fire_pat, 1 << VECS[v].chan, "cal pattern at fire");
      check("R4", o_calerr, VECS[v].exp_err, "cal error flag");
      check("R5", o_tok, 1, "token count");
      check("R5", o_hold_bad, 0, "hold during conv");
      check("R6", o_conv, N, "conv count");
      check("R6", o_order_bad, 0, "channel order");
      check("R7", o_up, VECS[v].exp_up, "upset flag");
      check("R8", o_end, 1, "packet end count");
      check("R8", o_seq, seq_exp % (1 << SQW), "sequence number");
      seq_exp++;
    end

    // R2: trigger and channel change while busy are ignored
    flip_at = 0; calbad = 1'b0;
    readout(1'b1, 3'd2, 1'b1);
    check("R2", o_end, 1, "packets with trigger while busy");
    check("R2", o_fire_pat, 1 << 2, "latched channel kept");
    check("R2", o_busy, RC + SC + 2 * N + 1 + 4 * N + 1, "latched mode kept");
    seq_exp++;

    // R8 wrap: packets 7 and 8 (seq 7, then 0)
    readout(1'b0, 3'd0, 1'b0);
    check("R8", o_seq, 7, "seq before wrap");
    readout(1'b0, 3'd0, 1'b0);
    check("R8", o_seq, 0, "seq wrap");
    check("R7", o_up, 0, "clean packet after wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule